// File: doc/BRIEF.md
# Datapath ALU with Latched Status Flags

This block is the arithmetic and logic unit of a small processor datapath. It chooses its first operand from the program counter, the destination register, the source register or a zero vector. It chooses its second operand from the source register or an immediate value. It then adds, subtracts, compares, applies a bitwise function, or shifts. The combinational result leaves on `result`. A registered copy of the result and a five-bit status word are updated on the clock edge under separate load enables.

The status word reports equality and two less-than relations between the selected operands, one unsigned and one signed. It also reports signed overflow and carry from the adder. For a shift, a signed amount taken from the low bits of either the source register or the immediate sets both the direction and the distance. During a compare the adder output is still visible on `result`, but `result_valid` drops, so the result register does not take the difference.

Top module: `dp_alu`

## Requirements
- R1: `a_sel` picks operand A: 0 = `pc_val`, 1 = `rdst_val`, 2 = `rsrc_val`, 3 = all zeros.
- R2: `b_sel_imm` picks operand B: 0 = `rsrc_val`, 1 = `imm_val`.
- R3: With `op_class` = 0, the result is (A + B' + k) mod 2^WIDTH. B' is B when `add_mode` = 1 and ~B when it is 0. k is 0 for add or 1 for subtract, plus one more when `carry_in` is 1.
- R4: In class 0, C is set when A + B' + k reaches 2^WIDTH or more. F is set when the signed sum of A, B' and k falls outside the signed WIDTH-bit range. In every other class, F and C are 0.
- R5: Z = (A == B), L = A < B unsigned, N = A < B signed. These hold in every class, and Z and L are never both set.
- R6: With `op_class` = 1, `logic_sel` gives 0 = A|B, 1 = A^B, 2 = A&B, 3 = zero.
- R7: With `op_class` = 2 or 3, the shift amount is the low SHAMT_W bits of the shift operand, read in two's complement. A positive amount shifts A left, a negative amount shifts it right by the magnitude, and zero passes A through unchanged.
- R8: On a right shift, `shift_arith` = 0 fills with zeros and `shift_arith` = 1 fills with copies of A's sign bit. Class 3 behaves the same as class 2.
- R9: `shift_src_imm` takes the shift operand from `rsrc_val` when 0 and from `imm_val` when 1.
- R10: When class 0 runs with `cmp_mode` = 1, the unit computes A − B and ignores `add_mode` and `carry_in`. `result` shows the difference and `result_valid` is 0. In every other case `result_valid` is 1.
- R11: `flags_q` = {Z,L,N,F,C} (bit 4 = Z down to bit 0 = C). It loads the current flags on a clock edge when `flag_we` = 1 and keeps its value otherwise.
- R12: `res_q` loads `result` on a clock edge only when `res_we` = 1 and `result_valid` = 1. Otherwise it keeps its value.
- R13: `clr` = 1 at a clock edge sets `res_q` and `flags_q` to zero. It takes priority over both load enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of both registers |
| op_class | input | 2 | Operation class: 0 arith, 1 logic, 2 shift, 3 shift (link) |
| logic_sel | input | 2 | Bitwise function select |
| shift_arith | input | 1 | Right-shift fill: 0 zeros, 1 sign |
| carry_in | input | 1 | Adds one to the arithmetic result |
| add_mode | input | 1 | 1 add, 0 subtract |
| cmp_mode | input | 1 | Compare: subtract for flags only |
| a_sel | input | 2 | Operand A source |
| b_sel_imm | input | 1 | Operand B source |
| shift_src_imm | input | 1 | Shift operand source |
| pc_val | input | WIDTH | Program counter value |
| rdst_val | input | WIDTH | Destination register value |
| rsrc_val | input | WIDTH | Source register value |
| imm_val | input | WIDTH | Immediate value |
| flag_we | input | 1 | Status register load enable |
| res_we | input | 1 | Result register load enable |
| result | output | WIDTH | Combinational ALU output |
| result_valid | output | 1 | Low during a compare |
| res_q | output | WIDTH | Registered result |
| flags_q | output | 5 | Registered {Z,L,N,F,C} |

## Verification
The bench builds the unit with WIDTH = 4 and SHAMT_W = 3. At that size every pair of operand values can be applied under every add, subtract, carry-in and compare setting, and under every bitwise function. With three amount bits, every shift amount from −4 to +3 is also covered. That range includes the right shift by the full width, where an arithmetic shift leaves only sign copies. Both the signed and the unsigned boundaries of overflow, carry and the two less-than flags are reached for all 256 operand pairs.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [1:0] {
    CLS_ARITH      = 2'b00,
    CLS_LOGIC      = 2'b01,
    CLS_SHIFT      = 2'b10,
    CLS_SHIFT_LINK = 2'b11
  } op_cls_e;

  typedef enum logic [1:0] {
    LG_OR   = 2'b00,
    LG_XOR  = 2'b01,
    LG_AND  = 2'b10,
    LG_NONE = 2'b11
  } lg_op_e;

  typedef enum logic [1:0] {
    ASRC_PC   = 2'b00,
    ASRC_DST  = 2'b01,
    ASRC_SRC  = 2'b10,
    ASRC_ZERO = 2'b11
  } a_src_e;

  // Bit 4 = Z ... bit 0 = C
  typedef struct packed {
    logic z;
    logic l;
    logic n;
    logic f;
    logic c;
  } flags_t;

  localparam int FLAG_W = 5;

endpackage

// File: rtl/dp_alu_opsel.sv
module dp_alu_opsel
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  a_src_e             a_src,
  input  logic               b_imm,
  input  logic [WIDTH-1:0]   pc_val,
  input  logic [WIDTH-1:0]   rdst_val,
  input  logic [WIDTH-1:0]   rsrc_val,
  input  logic [WIDTH-1:0]   imm_val,
  output logic [WIDTH-1:0]   opa,
  output logic [WIDTH-1:0]   opb
);

  always_comb begin
    case (a_src)
      ASRC_PC:   opa = pc_val;
      ASRC_DST:  opa = rdst_val;
      ASRC_SRC:  opa = rsrc_val;
      ASRC_ZERO: opa = '0;
      default:   opa = '0;
    endcase
    opb = b_imm ? imm_val : rsrc_val;
  end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = 4
) (
  input  op_cls_e            cls,
  input  lg_op_e             lgop,
  input  logic               shift_arith,
  input  logic               carry_in,
  input  logic               add_mode,
  input  logic               cmp_mode,
  input  logic               shift_imm,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  input  logic [SHAMT_W-1:0] sh_reg,
  input  logic [SHAMT_W-1:0] sh_imm,
  output logic [WIDTH-1:0]   result,
  output logic               result_valid,
  output flags_t             flags_nx
);

  localparam int EXT_W = WIDTH + 2;
  localparam int MAG_W = SHAMT_W + 1;

  // Unsigned sum with two guard bits: low bits are the result, top bits the carry.
  function automatic logic [EXT_W-1:0] sum_unsigned(
    input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] bx, input logic [1:0] k);
    return {2'b00, a} + {2'b00, bx} + {{WIDTH{1'b0}}, k};
  endfunction

  // Signed sum with two guard bits; returns the top three bits only.
  function automatic logic [2:0] sum_signed_top(
    input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] bx, input logic [1:0] k);
    logic [EXT_W-1:0] s;
    s = {{2{a[WIDTH-1]}}, a} + {{2{bx[WIDTH-1]}}, bx} + {{WIDTH{1'b0}}, k};
    return s[EXT_W-1:WIDTH-1];
  endfunction

  function automatic logic [WIDTH-1:0] logic_op(
    input lg_op_e op, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    case (op)
      LG_OR:   return a | b;
      LG_XOR:  return a ^ b;
      LG_AND:  return a & b;
      default: return '0;
    endcase
  endfunction

  // Signed amount: positive shifts left, negative shifts right by the magnitude.
  function automatic logic [WIDTH-1:0] shift_op(
    input logic [WIDTH-1:0] a, input logic [SHAMT_W-1:0] amt, input logic arith);
    logic [MAG_W-1:0] mag;
    if (amt[SHAMT_W-1]) begin
      mag = {1'b0, ~amt} + MAG_W'(1);
      if (arith) return $unsigned($signed(a) >>> mag);
      else       return a >> mag;
    end
    mag = {1'b0, amt};
    return a << mag;
  endfunction

  // Named internal events
  logic                 cmp_active;
  logic                 arith_sel;
  logic                 eff_add;
  logic                 eff_cin;
  logic [WIDTH-1:0]     b_x;
  logic [1:0]           k_in;
  logic [EXT_W-1:0]     sum_u;
  logic [2:0]           sum_s_top;
  logic                 carry_out;
  logic                 overflow;
  logic [SHAMT_W-1:0]   sh_amt;
  logic [WIDTH-1:0]     shifted;
  logic [WIDTH-1:0]     logic_res;

  always_comb begin
    arith_sel  = (cls == CLS_ARITH);
    cmp_active = arith_sel && cmp_mode;
    eff_add    = add_mode && !cmp_active;
    eff_cin    = carry_in && !cmp_active;
    b_x        = eff_add ? opb : ~opb;
    k_in       = {1'b0, !eff_add} + {1'b0, eff_cin};
    sum_u      = sum_unsigned(opa, b_x, k_in);
    sum_s_top  = sum_signed_top(opa, b_x, k_in);
    carry_out  = |sum_u[EXT_W-1:WIDTH];
    overflow   = (sum_s_top[2] != sum_s_top[1]) || (sum_s_top[1] != sum_s_top[0]);
    sh_amt     = shift_imm ? sh_imm : sh_reg;
    shifted    = shift_op(opa, sh_amt, shift_arith);
    logic_res  = logic_op(lgop, opa, opb);

    case (cls)
      CLS_ARITH:      result = sum_u[WIDTH-1:0];
      CLS_LOGIC:      result = logic_res;
      CLS_SHIFT:      result = shifted;
      CLS_SHIFT_LINK: result = shifted;
      default:        result = '0;
    endcase
    result_valid = !cmp_active;

    flags_nx.z = (opa == opb);
    flags_nx.l = (opa < opb);
    flags_nx.n = ($signed(opa) < $signed(opb));
    flags_nx.f = arith_sel && overflow;
    flags_nx.c = arith_sel && carry_out;
  end

endmodule

// File: rtl/dp_alu_regs.sv
module dp_alu_regs
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             flag_we,
  input  logic             res_we,
  input  logic [WIDTH-1:0] result,
  input  logic             result_valid,
  input  flags_t           flags_nx,
  output logic [WIDTH-1:0] res_q,
  output flags_t           flags_q
);

  always_ff @(posedge clk) begin
    if (clr) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (flag_we)
        flags_q <= flags_nx;
      if (res_we && result_valid)
        res_q <= result;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = 4
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic [1:0]           op_class,
  input  logic [1:0]           logic_sel,
  input  logic                 shift_arith,
  input  logic                 carry_in,
  input  logic                 add_mode,
  input  logic                 cmp_mode,
  input  logic [1:0]           a_sel,
  input  logic                 b_sel_imm,
  input  logic                 shift_src_imm,
  input  logic [WIDTH-1:0]     pc_val,
  input  logic [WIDTH-1:0]     rdst_val,
  input  logic [WIDTH-1:0]     rsrc_val,
  input  logic [WIDTH-1:0]     imm_val,
  input  logic                 flag_we,
  input  logic                 res_we,
  output logic [WIDTH-1:0]     result,
  output logic                 result_valid,
  output logic [WIDTH-1:0]     res_q,
  output logic [FLAG_W-1:0]    flags_q
);

  logic [WIDTH-1:0] opa;
  logic [WIDTH-1:0] opb;
  flags_t           flags_nx;
  flags_t           flags_r;

  dp_alu_opsel #(.WIDTH(WIDTH)) opsel_i (
    .a_src    (a_src_e'(a_sel)),
    .b_imm    (b_sel_imm),
    .pc_val   (pc_val),
    .rdst_val (rdst_val),
    .rsrc_val (rsrc_val),
    .imm_val  (imm_val),
    .opa      (opa),
    .opb      (opb)
  );

  dp_alu_core #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) core_i (
    .cls          (op_cls_e'(op_class)),
    .lgop         (lg_op_e'(logic_sel)),
    .shift_arith  (shift_arith),
    .carry_in     (carry_in),
    .add_mode     (add_mode),
    .cmp_mode     (cmp_mode),
    .shift_imm    (shift_src_imm),
    .opa          (opa),
    .opb          (opb),
    .sh_reg       (rsrc_val[SHAMT_W-1:0]),
    .sh_imm       (imm_val[SHAMT_W-1:0]),
    .result       (result),
    .result_valid (result_valid),
    .flags_nx     (flags_nx)
  );

  dp_alu_regs #(.WIDTH(WIDTH)) regs_i (
    .clk          (clk),
    .clr          (clr),
    .flag_we      (flag_we),
    .res_we       (res_we),
    .result       (result),
    .result_valid (result_valid),
    .flags_nx     (flags_nx),
    .res_q        (res_q),
    .flags_q      (flags_r)
  );

  assign flags_q = flags_r;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             clr,
  input logic             flag_we,
  input logic             res_we,
  input logic [WIDTH-1:0] result,
  input logic             result_valid,
  input logic [WIDTH-1:0] res_q,
  input logic [4:0]       flags_q,
  input logic [4:0]       flags_nx
);

  // Set by the first clear; guards against pre-reset register contents.
  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (clr) armed <= 1'b1;

  p_flag_load_r11: assert property (@(posedge clk) disable iff (!armed || clr)
    flag_we |=> flags_q == $past(flags_nx));

  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!armed || clr)
    !flag_we |=> $stable(flags_q));

  p_res_load_r12: assert property (@(posedge clk) disable iff (!armed || clr)
    (res_we && result_valid) |=> res_q == $past(result));

  p_res_hold_r12: assert property (@(posedge clk) disable iff (!armed || clr)
    !(res_we && result_valid) |=> $stable(res_q));

  p_clear_r13: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (res_q == '0) && (flags_q == '0));

  p_zl_excl_r5: assert property (@(posedge clk) disable iff (!armed || clr)
    !(flags_q[4] && flags_q[3]));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk          (clk),
  .clr          (clr),
  .flag_we      (flag_we),
  .res_we       (res_we),
  .result       (result),
  .result_valid (result_valid),
  .res_q        (res_q),
  .flags_q      (flags_q),
  .flags_nx     (flags_nx)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

  localparam int W    = 4;
  localparam int S    = 3;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic [1:0]   op_class = '0;
  logic [1:0]   logic_sel = '0;
  logic         shift_arith = 1'b0;
  logic         carry_in = 1'b0;
  logic         add_mode = 1'b0;
  logic         cmp_mode = 1'b0;
  logic [1:0]   a_sel = '0;
  logic         b_sel_imm = 1'b0;
  logic         shift_src_imm = 1'b0;
  logic [W-1:0] pc_val = '0;
  logic [W-1:0] rdst_val = '0;
  logic [W-1:0] rsrc_val = '0;
  logic [W-1:0] imm_val = '0;
  logic         flag_we = 1'b0;
  logic         res_we = 1'b0;
  logic [W-1:0] result;
  logic         result_valid;
  logic [W-1:0] res_q;
  logic [4:0]   flags_q;

  int n_vec = 0;
  int n_bad = 0;
  int prev_res = 0;
  int prev_flags = 0;

  always #2 clk = ~clk;

  dp_alu #(.WIDTH(W), .SHAMT_W(S)) dut_i (
    .clk(clk), .clr(clr), .op_class(op_class), .logic_sel(logic_sel),
    .shift_arith(shift_arith), .carry_in(carry_in), .add_mode(add_mode),
    .cmp_mode(cmp_mode), .a_sel(a_sel), .b_sel_imm(b_sel_imm),
    .shift_src_imm(shift_src_imm), .pc_val(pc_val), .rdst_val(rdst_val),
    .rsrc_val(rsrc_val), .imm_val(imm_val), .flag_we(flag_we), .res_we(res_we),
    .result(result), .result_valid(result_valid), .res_q(res_q), .flags_q(flags_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v & (1 << (W - 1))) != 0 ? v - (1 << W) : v;
  endfunction

  task automatic model(input int cls, lg, ar, cin, add, cmp, shimm,
                       input int a, b, rs, im,
                       output int res, output int valid, output int flg);
    int z, l, n, f, c, bx, k, tot, st, e_add, amt, r;
    z = (a == b); l = (a < b); n = (sgn(a) < sgn(b)); f = 0; c = 0;
    valid = 1; res = 0;
    if (cls == 0) begin
      e_add = add && !cmp;
      bx  = e_add ? b : (~b & MASK);
      k   = (e_add ? 0 : 1) + ((cin && !cmp) ? 1 : 0);
      tot = a + bx + k;
      res = tot & MASK;
      c   = tot > MASK;
      st  = sgn(a) + sgn(bx) + k;
      f   = (st > (1 << (W - 1)) - 1) || (st < -(1 << (W - 1)));
      valid = !cmp;
    end else if (cls == 1) begin
      case (lg)
        0: res = a | b;
        1: res = a ^ b;
        2: res = a & b;
        default: res = 0;
      endcase
    end else begin
      amt = (shimm ? im : rs) & ((1 << S) - 1);
      if (amt >= (1 << (S - 1))) amt = amt - (1 << S);
      if (amt >= 0) res = (a << amt) & MASK;
      else begin
        r = a;
        for (int i = 0; i < -amt; i++)
          r = ar ? ((r >> 1) | (r & (1 << (W - 1)))) : (r >> 1);
        res = r;
      end
    end
    flg = (z << 4) | (l << 3) | (n << 2) | (f << 1) | c;
  endtask

  task automatic apply(input string req, input int cls, lg, ar, cin, add, cmp,
                       input int asel, bimm, shimm, pc, rd, rs, im,
                       input int fwe, rwe);
    int a, b, res, valid, flg, er, ef;
    @(negedge clk);
    op_class = 2'(cls); logic_sel = 2'(lg); shift_arith = 1'(ar);
    carry_in = 1'(cin); add_mode = 1'(add); cmp_mode = 1'(cmp);
    a_sel = 2'(asel); b_sel_imm = 1'(bimm); shift_src_imm = 1'(shimm);
    pc_val = W'(pc); rdst_val = W'(rd); rsrc_val = W'(rs); imm_val = W'(im);
    flag_we = 1'(fwe); res_we = 1'(rwe); clr = 1'b0;
    case (asel)
      0: a = pc; 1: a = rd; 2: a = rs; default: a = 0;
    endcase
    b = bimm ? im : rs;
    model(cls, lg, ar, cin, add, cmp, shimm, a, b, rs, im, res, valid, flg);
    #1;
    chk({req, " result"}, 32'(result), 32'(res));
    chk("R10 result_valid", 32'(result_valid), 32'(valid));
    ef = fwe ? flg : prev_flags;
    er = (rwe && valid) ? res : prev_res;
    @(posedge clk); #1;
    chk("R11 flags_q", 32'(flags_q), 32'(ef));
    chk("R12 res_q", 32'(res_q), 32'(er));
    prev_flags = ef; prev_res = er;
  endtask

  task automatic do_clear(input int fwe, rwe);
    @(negedge clk);
    clr = 1'b1; flag_we = 1'(fwe); res_we = 1'(rwe);
    op_class = 2'd1; logic_sel = 2'd0; a_sel = 2'd0; pc_val = W'(MASK);
    @(posedge clk); #1;
    chk("R13 clear res_q", 32'(res_q), 32'd0);
    chk("R13 clear flags_q", 32'(flags_q), 32'd0);
    prev_res = 0; prev_flags = 0;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_clear(1, 1);   // R13 reset state, clear beats both enables

    // R1: A source select, B = imm = 0 under OR
    apply("R1 a=pc",   1, 0, 0, 0, 0, 0, 0, 1, 0, 3, 5, 9, 0, 1, 1);
    apply("R1 a=rdst", 1, 0, 0, 0, 0, 0, 1, 1, 0, 3, 5, 9, 0, 1, 1);
    apply("R1 a=rsrc", 1, 0, 0, 0, 0, 0, 2, 1, 0, 3, 5, 9, 0, 1, 1);
    apply("R1 a=zero", 1, 0, 0, 0, 0, 0, 3, 1, 0, 3, 5, 9, 0, 1, 1);
    // R2: B source select with A = zero
    apply("R2 b=rsrc", 1, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0, 6, 10, 1, 1);
    apply("R2 b=imm",  1, 0, 0, 0, 0, 0, 3, 1, 0, 0, 0, 6, 10, 1, 1);

    // R11/R12: enables low, status and result must hold
    apply("R11 R12 hold", 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 15, 15, 15, 0, 0);
    apply("R11 R12 hold2", 1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 7, 0, 0, 0, 0);

    // R3 R4 R5 R10: exhaustive arithmetic/compare
    for (int a = 0; a <= MASK; a++)
      for (int b = 0; b <= MASK; b++)
        for (int m = 0; m < 8; m++)
          apply("R3 R4 R5 R10 arith", 0, 0, 0, m & 1, (m >> 1) & 1, (m >> 2) & 1,
                1, (a ^ b) & 1, 0, 0, a, b, b, 1, 1);

    // R6 R4: exhaustive logic ops (F,C must be zero)
    for (int a = 0; a <= MASK; a++)
      for (int b = 0; b <= MASK; b++)
        for (int lg = 0; lg < 4; lg++)
          apply("R6 R4 logic", 1, lg, 0, 1, 1, 1, 1, 0, 0, 0, a, b, b, 1, 1);

    // R7 R8 R9: exhaustive shifts, both classes, both sources, both fills
    for (int a = 0; a <= MASK; a++)
      for (int sh = 0; sh <= MASK; sh++)
        for (int m = 0; m < 8; m++) begin
          int shimm = m & 1;
          int other = (sh + 5) & MASK;
          apply("R7 R8 R9 shift", 2 + ((m >> 2) & 1), 0, (m >> 1) & 1, 1, 1, 1,
                1, 0, shimm, 0, a, shimm ? other : sh, shimm ? sh : other, 1, 1);
        end

    do_clear(0, 0);   // R13 clear with enables low
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule